// File: doc/BRIEF.md
# Partial-Width Register File

This block holds the general-purpose integer state of a 64-bit core. It has sixteen 64-bit registers, one write port and two read ports. Every access names a register index, an operand size and a high-byte select. The block also holds a 64-bit instruction pointer and a 64-bit flags word.

The size of a write decides how the new value merges with the old one. A 32-bit write fills the low half and clears the upper half. An 8-bit or 16-bit write changes only the bits it addresses and keeps the rest of the register. Byte accesses can reach bits 15:8 of the first four registers. That happens either through the explicit high-byte select or through byte indices 4 to 7 when the extended prefix is absent. With the prefix present, byte indices 4 to 7 reach the low byte of registers 4 to 7.

Reads are combinational. Each read returns the selected slice zero-extended to 64 bits. Writes land on the clock edge, so a read in the same cycle as a write sees the value from before the write.

Top module: `srf_regfile`

## Requirements
- R1: After an active-low reset, all sixteen registers, the instruction pointer and the stored flags are zero. The flags output shows 64'h2 because bit 1 always reads as one.
- R2: A write with size code 3 (64 bits) replaces the whole register. A read with size code 3 returns all 64 bits.
- R3: A write with size code 2 (32 bits) stores write data bits 31:0 in register bits 31:0 and forces register bits 63:32 to zero.
- R4: A write with size code 1 (16 bits) or size code 0 (8 bits) changes only the addressed 16 or 8 bits. Every other bit of the register keeps its value.
- R5: A read returns the addressed slice in the low bits of the read data, with all bits above the slice at zero. Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R6: With the high-byte select set, size code 0, index 0 to 3 and the prefix input low, the access targets bits 15:8 of that register.
- R7: With the prefix low, size code 0 and the high-byte select clear, indices 4 to 7 target bits 15:8 of registers 0 to 3 (index minus 4).
- R8: With the prefix high, size code 0 and the high-byte select clear, indices 4 to 15 target bits 7:0 of the register with that index.
- R9: The port's illegal flag is raised when the high-byte select is set together with any of: the prefix high, an index of 4 or more, or a size code other than 0. An illegal write changes no register. An illegal read returns zero.
- R10: A read of a register in the same cycle as a write to that register returns the value from before the write. There is no bypass.
- R11: The instruction pointer loads the load value when load is high. Otherwise, when increment is high, it adds the 4-bit length. Load wins over increment. With neither input high, it holds its value.
- R12: When flag load is high, the flags word takes the load value. The flags output always shows bit 1 as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_hi | input | 1 | Write high-byte select |
| wr_xp | input | 1 | Write extended prefix present |
| wr_data | input | 64 | Write data, slice in low bits |
| wr_illegal | output | 1 | Write request is illegal |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_xp | input | 1 | Read port 0 extended prefix |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 request is illegal |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_xp | input | 1 | Read port 1 extended prefix |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 request is illegal |
| ip_load | input | 1 | Load instruction pointer |
| ip_load_val | input | 64 | Instruction pointer load value |
| ip_inc | input | 1 | Advance instruction pointer |
| ip_inc_len | input | 4 | Advance amount in bytes |
| ip_o | output | 64 | Instruction pointer |
| fl_load | input | 1 | Load flags |
| fl_load_val | input | 64 | Flags load value |
| flags_o | output | 64 | Flags, bit 1 forced to one |

## Verification
Each register is first filled with a distinct all-bits-set-and-varied 64-bit pattern. Writes of each size then follow, so any bit that a narrow write wrongly touches shows up, and any stale upper half left by a 32-bit write shows up too.

Byte accesses are repeated with the same index under prefix low, prefix high and the explicit high-byte select. This separates high-byte aliasing from low-byte access on registers 4 to 7.

Illegal combinations are issued against registers that hold known values, to prove the write was dropped. Reads aimed at the register being written in the same cycle separate old-value reads from a forwarding path.

// File: rtl/srf_pkg.sv
// Shared definitions for the partial-width register file.
// Assumes a two-bit size code; the encoding is fixed by the port contract.
package srf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_FULL = 2'd3
    } srf_size_e;

    localparam int unsigned SRF_HI_SHIFT = 8;
    localparam int unsigned SRF_FLAG_ONE_BIT = 1;

endpackage

// File: rtl/srf_port_decode.sv
// Turns one port's (index, size, high select, prefix) into a physical
// register, a lane shift, a width mask and an illegal flag.
// Assumes the first four registers are the only ones with a bits 15:8 view.
module srf_port_decode
    import srf_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IDXW = 4
) (
    input  logic [IDXW-1:0] idx,
    input  logic [1:0]      size,
    input  logic            hi,
    input  logic            xp,
    output logic [IDXW-1:0] phys,
    output logic            hi_lane,
    output logic [XLEN-1:0] mask,
    output logic            zext32,
    output logic            illegal
);

    logic low_four;
    logic alias_hi;

    // Classify the index and find legacy high-byte aliasing.
    always_comb begin
        low_four = (idx < IDXW'(4));
        alias_hi = (size == SZ_BYTE) && !hi && !xp
                   && (idx >= IDXW'(4)) && (idx <= IDXW'(7));
    end

    // Resolve physical register, lane and legality.
    always_comb begin
        illegal = hi && (xp || !low_four || (size != SZ_BYTE));
        phys    = alias_hi ? (idx - IDXW'(4)) : idx;
        hi_lane = alias_hi || (hi && !illegal);
        zext32  = (size == SZ_WORD);
    end

    // Build the width mask for the size code.
    always_comb begin
        case (size)
            SZ_BYTE: mask = {{(XLEN-8){1'b0}}, 8'hFF};
            SZ_HALF: mask = {{(XLEN-16){1'b0}}, 16'hFFFF};
            SZ_WORD: mask = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
            default: mask = '1;
        endcase
    end

endmodule

// File: rtl/srf_store.sv
// Register array with one merging write port and NRD slicing read ports.
// Assumes decoded requests; reads are combinational and see pre-write state.
module srf_store
    import srf_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 16,
    parameter int unsigned NRD  = 2,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            w_en,
    input  logic [IDXW-1:0] w_phys,
    input  logic            w_hi,
    input  logic [XLEN-1:0] w_mask,
    input  logic            w_zext,
    input  logic [XLEN-1:0] w_data,
    input  logic [IDXW-1:0] r_phys [NRD],
    input  logic            r_hi   [NRD],
    input  logic [XLEN-1:0] r_mask [NRD],
    input  logic            r_bad  [NRD],
    output logic [XLEN-1:0] r_val  [NRD]
);

    logic [XLEN-1:0] q [NREG];
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] lane;
    logic [XLEN-1:0] shifted;

    // Form the new register value from the size-dependent merge rule.
    always_comb begin
        lane    = w_hi ? (w_mask << SRF_HI_SHIFT) : w_mask;
        shifted = w_hi ? (w_data << SRF_HI_SHIFT) : w_data;
        if (w_zext)
            merged = w_data & w_mask;
        else
            merged = (q[w_phys] & ~lane) | (shifted & lane);
    end

    // Hold register state; clear on reset, update one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q[i] <= '0;
        end else if (w_en) begin
            q[w_phys] <= merged;
        end
    end

    // One slicing read path per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [XLEN-1:0] raw;
        always_comb begin
            raw      = r_hi[p] ? (q[r_phys[p]] >> SRF_HI_SHIFT) : q[r_phys[p]];
            r_val[p] = r_bad[p] ? '0 : (raw & r_mask[p]);
        end
    end

endmodule

// File: rtl/srf_ctl_regs.sv
// Instruction pointer and flags word with load and advance controls.
// Assumes load takes priority over advance; flags bit 1 is presented as one.
module srf_ctl_regs
    import srf_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ip_load,
    input  logic [XLEN-1:0] ip_load_val,
    input  logic            ip_inc,
    input  logic [ILW-1:0]  ip_inc_len,
    input  logic            fl_load,
    input  logic [XLEN-1:0] fl_load_val,
    output logic [XLEN-1:0] ip_o,
    output logic [XLEN-1:0] flags_o
);

    logic [XLEN-1:0] ip_q;
    logic [XLEN-1:0] fl_q;

    // Update the instruction pointer: load first, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip_q <= '0;
        else if (ip_load)
            ip_q <= ip_load_val;
        else if (ip_inc)
            ip_q <= ip_q + XLEN'(ip_inc_len);
    end

    // Update the stored flags word on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fl_q <= '0;
        else if (fl_load)
            fl_q <= fl_load_val;
    end

    // Present outputs with the fixed-one flag bit.
    always_comb begin
        ip_o    = ip_q;
        flags_o = fl_q | (XLEN'(1) << SRF_FLAG_ONE_BIT);
    end

endmodule

// File: rtl/srf_regfile.sv
// Top of the partial-width register file: three port decoders, the
// register array and the control registers.
// Assumes two read ports and one write port, all with size-coded access.
module srf_regfile
    import srf_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 16,
    parameter int unsigned ILW  = 4,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned NRD  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [1:0]      wr_size,
    input  logic            wr_hi,
    input  logic            wr_xp,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_illegal,
    input  logic [IDXW-1:0] rd0_idx,
    input  logic [1:0]      rd0_size,
    input  logic            rd0_hi,
    input  logic            rd0_xp,
    output logic [XLEN-1:0] rd0_data,
    output logic            rd0_illegal,
    input  logic [IDXW-1:0] rd1_idx,
    input  logic [1:0]      rd1_size,
    input  logic            rd1_hi,
    input  logic            rd1_xp,
    output logic [XLEN-1:0] rd1_data,
    output logic            rd1_illegal,
    input  logic            ip_load,
    input  logic [XLEN-1:0] ip_load_val,
    input  logic            ip_inc,
    input  logic [ILW-1:0]  ip_inc_len,
    output logic [XLEN-1:0] ip_o,
    input  logic            fl_load,
    input  logic [XLEN-1:0] fl_load_val,
    output logic [XLEN-1:0] flags_o
);

    logic [IDXW-1:0] w_phys;
    logic            w_hi_lane;
    logic [XLEN-1:0] w_mask;
    logic            w_zext;
    logic            w_bad;

    logic [IDXW-1:0] a_idx  [NRD];
    logic [1:0]      a_size [NRD];
    logic            a_hi   [NRD];
    logic            a_xp   [NRD];
    logic [IDXW-1:0] r_phys [NRD];
    logic            r_hi   [NRD];
    logic [XLEN-1:0] r_mask [NRD];
    logic            r_zext [NRD];
    logic            r_bad  [NRD];
    logic [XLEN-1:0] r_val  [NRD];

    // Gather read-port requests into arrays for the generate loop.
    always_comb begin
        a_idx[0] = rd0_idx;  a_size[0] = rd0_size;  a_hi[0] = rd0_hi;  a_xp[0] = rd0_xp;
        a_idx[1] = rd1_idx;  a_size[1] = rd1_size;  a_hi[1] = rd1_hi;  a_xp[1] = rd1_xp;
    end

    srf_port_decode #(.XLEN(XLEN), .IDXW(IDXW)) u_wdec (
        .idx(wr_idx), .size(wr_size), .hi(wr_hi), .xp(wr_xp),
        .phys(w_phys), .hi_lane(w_hi_lane), .mask(w_mask),
        .zext32(w_zext), .illegal(w_bad)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rdec
        srf_port_decode #(.XLEN(XLEN), .IDXW(IDXW)) u_rdec (
            .idx(a_idx[p]), .size(a_size[p]), .hi(a_hi[p]), .xp(a_xp[p]),
            .phys(r_phys[p]), .hi_lane(r_hi[p]), .mask(r_mask[p]),
            .zext32(r_zext[p]), .illegal(r_bad[p])
        );
    end

    srf_store #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n),
        .w_en(wr_en && !w_bad), .w_phys(w_phys), .w_hi(w_hi_lane),
        .w_mask(w_mask), .w_zext(w_zext), .w_data(wr_data),
        .r_phys(r_phys), .r_hi(r_hi), .r_mask(r_mask), .r_bad(r_bad),
        .r_val(r_val)
    );

    srf_ctl_regs #(.XLEN(XLEN), .ILW(ILW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ip_load(ip_load), .ip_load_val(ip_load_val),
        .ip_inc(ip_inc), .ip_inc_len(ip_inc_len),
        .fl_load(fl_load), .fl_load_val(fl_load_val),
        .ip_o(ip_o), .flags_o(flags_o)
    );

    // Drive the port-level outputs.
    always_comb begin
        wr_illegal  = w_bad;
        rd0_data    = r_val[0];
        rd1_data    = r_val[1];
        rd0_illegal = r_bad[0];
        rd1_illegal = r_bad[1];
    end

endmodule

// File: rtl/srf_regfile_chk.sv
// Port-level properties of srf_regfile, attached with bind below.
// Assumes synchronous active-low reset on rst_n.
module srf_regfile_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned ILW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      rd0_size,
    input logic            rd0_hi,
    input logic            rd0_xp,
    input logic [XLEN-1:0] rd0_data,
    input logic            rd0_illegal,
    input logic [XLEN-1:0] rd1_data,
    input logic            rd1_illegal,
    input logic            wr_hi,
    input logic            wr_xp,
    input logic            wr_illegal,
    input logic            ip_load,
    input logic [XLEN-1:0] ip_load_val,
    input logic            ip_inc,
    input logic [ILW-1:0]  ip_inc_len,
    input logic [XLEN-1:0] ip_o,
    input logic [XLEN-1:0] flags_o
);

    // R12
    flag_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1] == 1'b1);

    // R11
    ip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> ip_o == $past(ip_load_val));

    // R11
    ip_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_inc && !ip_load) |=> ip_o == $past(ip_o) + XLEN'($past(ip_inc_len)));

    // R11
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_inc && !ip_load) |=> $stable(ip_o));

    // R9
    hi_xp_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && wr_xp) |-> wr_illegal);

    // R9
    rd0_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_illegal |-> rd0_data == '0);

    // R9
    rd1_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_illegal |-> rd1_data == '0);

    // R5
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'd0) |-> rd0_data[XLEN-1:8] == '0);

    // R5
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'd1) |-> rd0_data[XLEN-1:16] == '0);

    // R9
    rd0_xp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_hi && rd0_xp) |-> rd0_illegal);

endmodule

bind srf_regfile srf_regfile_chk #(.XLEN(XLEN), .ILW(ILW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_xp(rd0_xp),
    .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .wr_hi(wr_hi), .wr_xp(wr_xp), .wr_illegal(wr_illegal),
    .ip_load(ip_load), .ip_load_val(ip_load_val),
    .ip_inc(ip_inc), .ip_inc_len(ip_inc_len),
    .ip_o(ip_o), .flags_o(flags_o)
);

// File: tb/srf_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench for srf_regfile: a behavioural model compared on every clock.
module srf_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0;
    logic [3:0]  wr_idx = 0;
    logic [1:0]  wr_size = 0;
    logic        wr_hi = 0, wr_xp = 0;
    logic [63:0] wr_data = 0;
    logic        wr_illegal;
    logic [3:0]  rd0_idx = 0, rd1_idx = 0;
    logic [1:0]  rd0_size = 3, rd1_size = 3;
    logic        rd0_hi = 0, rd0_xp = 0, rd1_hi = 0, rd1_xp = 0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_illegal, rd1_illegal;
    logic        ip_load = 0, ip_inc = 0, fl_load = 0;
    logic [63:0] ip_load_val = 0, fl_load_val = 0;
    logic [3:0]  ip_inc_len = 0;
    logic [63:0] ip_o, flags_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_reg [16];
    logic [63:0] m_ip, m_fl;

    always #4 clk = ~clk;

    srf_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_xp(wr_xp), .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_xp(rd0_xp),
        .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi), .rd1_xp(rd1_xp),
        .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
        .ip_load(ip_load), .ip_load_val(ip_load_val), .ip_inc(ip_inc),
        .ip_inc_len(ip_inc_len), .ip_o(ip_o),
        .fl_load(fl_load), .fl_load_val(fl_load_val), .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Illegal when high select pairs with prefix, upper index or non-byte size.
    function automatic bit m_bad(input int idx, input int sz, input bit hi, input bit xp);
        return hi && (xp || idx >= 4 || sz != 0);
    endfunction

    // Map a request to (register, high lane) from the byte-view rules.
    function automatic void m_map(input int idx, input int sz, input bit hi, input bit xp,
                                  output int r, output bit h);
        r = idx; h = hi;
        if (sz == 0 && !hi && !xp && idx >= 4 && idx <= 7) begin r = idx - 4; h = 1; end
    endfunction

    function automatic logic [63:0] m_read(input int idx, input int sz, input bit hi, input bit xp);
        int r; bit h; logic [63:0] v;
        if (m_bad(idx, sz, hi, xp)) return 64'h0;
        m_map(idx, sz, hi, xp, r, h);
        v = m_reg[r];
        if (h) v = v >> 8;
        case (sz)
            0: return {56'h0, v[7:0]};
            1: return {48'h0, v[15:0]};
            2: return {32'h0, v[31:0]};
            default: return v;
        endcase
    endfunction

    task automatic m_write();
        int r; bit h;
        if (!wr_en || m_bad(wr_idx, wr_size, wr_hi, wr_xp)) return;
        m_map(wr_idx, wr_size, wr_hi, wr_xp, r, h);
        case (wr_size)
            3: m_reg[r] = wr_data;
            2: m_reg[r] = {32'h0, wr_data[31:0]};
            1: m_reg[r][15:0] = wr_data[15:0];
            default: if (h) m_reg[r][15:8] = wr_data[7:0]; else m_reg[r][7:0] = wr_data[7:0];
        endcase
    endtask

    // One clock: compare reads before the edge, update model, compare state after.
    task automatic cyc(input string req);
        logic [63:0] e0, e1;
        #1;
        e0 = m_read(rd0_idx, rd0_size, rd0_hi, rd0_xp);
        e1 = m_read(rd1_idx, rd1_size, rd1_hi, rd1_xp);
        chk(rd0_data === e0, {req, " rd0"}, rd0_data, e0);
        chk(rd1_data === e1, {req, " rd1"}, rd1_data, e1);
        chk(wr_illegal === m_bad(wr_idx, wr_size, wr_hi, wr_xp), {req, " wr_illegal"},
            64'(wr_illegal), 64'(m_bad(wr_idx, wr_size, wr_hi, wr_xp)));
        chk(rd0_illegal === m_bad(rd0_idx, rd0_size, rd0_hi, rd0_xp), {req, " rd0_illegal"},
            64'(rd0_illegal), 64'(m_bad(rd0_idx, rd0_size, rd0_hi, rd0_xp)));
        @(posedge clk);
        m_write();
        if (ip_load) m_ip = ip_load_val; else if (ip_inc) m_ip = m_ip + 64'(ip_inc_len);
        if (fl_load) m_fl = fl_load_val;
        @(negedge clk);
        chk(ip_o === m_ip, {req, " ip"}, ip_o, m_ip);
        chk(flags_o === (m_fl | 64'h2), {req, " flags"}, flags_o, m_fl | 64'h2);
        wr_en = 0; ip_load = 0; ip_inc = 0; fl_load = 0;
    endtask

    task automatic wr(input int idx, input int sz, input bit hi, input bit xp, input logic [63:0] d);
        wr_en = 1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_hi = hi; wr_xp = xp; wr_data = d;
    endtask

    task automatic rd(input int p, input int idx, input int sz, input bit hi, input bit xp);
        if (p == 0) begin rd0_idx = 4'(idx); rd0_size = 2'(sz); rd0_hi = hi; rd0_xp = xp; end
        else        begin rd1_idx = 4'(idx); rd1_size = 2'(sz); rd1_hi = hi; rd1_xp = xp; end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 64'h0;
        m_ip = 0; m_fl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: every register, ip and flags after reset
        for (int i = 0; i < 16; i++) begin rd(0, i, 3, 0, 0); rd(1, 15 - i, 3, 0, 0); cyc("R1"); end
        // R2: full-width fill with distinct patterns
        for (int i = 0; i < 16; i++) begin
            wr(i, 3, 0, 0, 64'hA5C3_0F96_7E18_D24B ^ (64'(i) * 64'h0101_0101_0101_0101));
            rd(0, i, 3, 0, 0); cyc("R2");
        end
        for (int i = 0; i < 16; i++) begin rd(0, i, 3, 0, 0); rd(1, i, 3, 0, 0); cyc("R2"); end
        // R3: 32-bit write clears the upper half
        wr(3, 2, 0, 0, 64'hFFFF_FFFF_1234_5678); cyc("R3");
        rd(0, 3, 3, 0, 0); cyc("R3");
        wr(11, 2, 0, 1, 64'h0); cyc("R3");
        rd(0, 11, 3, 0, 0); cyc("R3");
        // R4: narrow writes keep other bits
        wr(9, 1, 0, 1, 64'hFFFF_FFFF_FFFF_BEEF); rd(0, 9, 3, 0, 0); cyc("R4");
        wr(12, 0, 0, 1, 64'h0000_0000_0000_0011); rd(0, 12, 3, 0, 0); cyc("R4");
        rd(0, 9, 3, 0, 0); rd(1, 12, 3, 0, 0); cyc("R4");
        // R5: each read size from the same register
        for (int s = 0; s < 4; s++) begin rd(0, 14, s, 0, 1); rd(1, 2, s, 0, 0); cyc("R5"); end
        // R6: explicit high-byte select
        wr(1, 0, 1, 0, 64'h0000_0000_0000_00C7); cyc("R6");
        rd(0, 1, 3, 0, 0); rd(1, 1, 0, 1, 0); cyc("R6");
        // R7: legacy byte index 5 is high byte of register 1
        wr(5, 0, 0, 0, 64'h0000_0000_0000_005A); rd(0, 5, 0, 0, 0); cyc("R7");
        rd(0, 1, 3, 0, 0); rd(1, 5, 3, 0, 0); cyc("R7");
        // R8: with prefix, byte index 5 is low byte of register 5
        wr(5, 0, 0, 1, 64'h0000_0000_0000_0033); rd(0, 5, 0, 0, 1); cyc("R8");
        rd(0, 5, 3, 0, 0); rd(1, 1, 3, 0, 0); cyc("R8");
        wr(13, 0, 0, 1, 64'h0000_0000_0000_0044); rd(0, 13, 0, 0, 1); cyc("R8");
        rd(0, 13, 3, 0, 0); cyc("R8");
        // R9: illegal combinations are dropped and read as zero
        wr(2, 0, 1, 1, 64'hFF); rd(0, 2, 0, 1, 1); cyc("R9");
        wr(6, 0, 1, 0, 64'hFF); rd(0, 6, 0, 1, 0); cyc("R9");
        wr(0, 1, 1, 0, 64'hFFFF); rd(1, 0, 2, 1, 0); cyc("R9");
        rd(0, 2, 3, 0, 0); rd(1, 6, 3, 0, 0); cyc("R9");
        rd(0, 0, 3, 0, 0); cyc("R9");
        // R10: same-cycle read of the register being written
        wr(7, 3, 0, 0, 64'h1111_2222_3333_4444); rd(0, 7, 3, 0, 0); rd(1, 7, 2, 0, 0); cyc("R10");
        wr(7, 2, 0, 0, 64'h5555_6666_7777_8888); cyc("R10");
        cyc("R10");
        // R11: ip load, advance, priority and hold
        ip_load = 1; ip_load_val = 64'hFFFF_FFFF_FFFF_FFF8; cyc("R11");
        ip_inc = 1; ip_inc_len = 4'd15; cyc("R11");
        ip_inc = 1; ip_inc_len = 4'd3; cyc("R11");
        ip_load = 1; ip_inc = 1; ip_load_val = 64'h0000_7000_0000_1000; cyc("R11");
        cyc("R11");
        // R12: flags load with bit 1 forced
        fl_load = 1; fl_load_val = 64'h0000_0000_0000_08D5; cyc("R12");
        fl_load = 1; fl_load_val = 64'hFFFF_FFFF_FFFF_FFFD; cyc("R12");
        fl_load = 1; fl_load_val = 64'h0; cyc("R12");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule